// File: doc/BRIEF.md
# Multi-Channel Converter Code Register Bank

This block is a small memory-mapped register bank that sits between a processor bus and a set of analog output converters. Each channel owns one control register and one data register. Software writes a 12-bit conversion code into the data register. The block then presents that code on the converter code port. The port follows the data register on every clock, or, in timer mode, it loads only when an external timer strobe arrives.

The control register also does three other jobs. It picks the reference range driven to the analog side. A range of zero powers the channel down and drops its output enable. A run bit, while low, holds the data register at zero. Reserved bits read back as zero and cannot be set. Reads come back one clock after the request on a registered read-data bus.

Top module: `dacc_regbank`

## Requirements
- R1: After reset, every control and data register reads 0, every code port is 0, every output enable is 0 and every range port is 00.
- R2: Channel n's control register sits at byte offset 8n and its data register at 8n+4. When a read is requested, the value appears on the read-data bus after the next rising edge.
- R3: In a control register, only bits [5:4] and [1:0] can be set. Bits [7:6] and [3:2] always read 0, and writing 1 to them has no effect.
- R4: The 12-bit code is written from and read back at data bits [27:16]. Data bits [31:28] and [15:0] always read 0.
- R5: Control bit 4 is the run bit. From the cycle after it is 0, the channel's data register reads 0. A data write made while it is 0 is lost, and setting the bit back to 1 does not restore any value.
- R6: When control bit 5 is 0 (immediate mode), the code port takes a newly written code one clock after the data register takes the write.
- R7: When control bit 5 is 1 (timer mode), the code port changes only on a rising edge where the timer strobe is high. At that edge it loads the data register contents held before the edge, so a write made on the same edge appears only at the next strobe.
- R8: The range port equals control bits [1:0] (00 off, 01 external reference, 10 internal reference, 11 supply). While the range is 00, the output enable is 0 and the code port reads 0. Selecting a nonzero range restores the held code.
- R9: Reads of offsets other than 8n and 8n+4 for an existing channel return 0, and writes to them change no register or port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write request, taken on the rising edge |
| bus_rd_i | input | 1 | Read request, data valid after the rising edge |
| bus_addr_i | input | ADDR_W (6) | Byte offset within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| tmr_upd_i | input | 1 | Timer update strobe |
| dac_code_o | output | NUM_CH*12 (48) | Converter codes, channel n at [12n+11:12n] |
| dac_oe_o | output | NUM_CH (4) | Output enable per channel |
| dac_range_o | output | NUM_CH*2 (8) | Range select per channel, channel n at [2n+1:2n] |

## Verification
The timer strobe and a bus write to the same channel's data register can land on the same rising edge. The two then compete for the output code. The bench provokes this by raising the strobe and the write together on a timer-mode channel whose data register already holds a different code. The code port must show the earlier code after that edge while a read of the data register returns the new one. The new code must reach the port only at the following strobe.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int CODE_W    = 12;
    localparam int BUS_W     = 32;
    localparam int CTRL_W    = 8;
    localparam int CODE_LSB  = 16;
    localparam int OFS_W     = 3;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h33;
    localparam logic [OFS_W-1:0]  OFS_CTRL  = 3'd0;
    localparam logic [OFS_W-1:0]  OFS_DATA  = 3'd4;

    typedef enum logic [1:0] {
        RNG_OFF    = 2'b00,
        RNG_EXTREF = 2'b01,
        RNG_INTREF = 2'b10,
        RNG_SUPPLY = 2'b11
    } range_e;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       upd_tmr;
        logic       run;
        logic [1:0] rsv_lo;
        range_e     rng;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } regsel_e;

    function automatic regsel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        if (ofs == OFS_CTRL)      return SEL_CTRL;
        else if (ofs == OFS_DATA) return SEL_DATA;
        else                      return SEL_NONE;
    endfunction

    function automatic logic [BUS_W-1:0] pack_code(input logic [CODE_W-1:0] c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CODE_LSB +: CODE_W] = c;
        return w;
    endfunction

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
    import dacc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output regsel_e           sel_o,
    output logic [NUM_CH-1:0] ch_oh_o
);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0] idx;
    regsel_e          sel;

    assign idx   = addr_i[ADDR_W-1:OFS_W];
    assign sel   = decode_ofs(addr_i[OFS_W-1:0]);
    assign sel_o = sel;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_oh_o[i] = (idx == IDX_W'(i)) && (sel != SEL_NONE);
    end

endmodule

// File: rtl/dacc_chan.sv
module dacc_chan
    import dacc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_data_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              tmr_upd_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CODE_W-1:0] data_o,
    output logic [CODE_W-1:0] code_o,
    output logic              oe_o,
    output logic [1:0]        range_o
);
    ctrl_t             ctrl_q;
    logic [CTRL_W-1:0] ctrl_bits;
    logic [CODE_W-1:0] data_q;
    logic [CODE_W-1:0] out_q;
    logic              powered;

    assign ctrl_bits = ctrl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          ctrl_q <= '0;
        else if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0] & CTRL_MASK);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)            data_q <= '0;
        else if (!ctrl_q.run) data_q <= '0;
        else if (wr_data_i)   data_q <= wdata_i[CODE_LSB +: CODE_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                            out_q <= '0;
        else if (!ctrl_q.upd_tmr || tmr_upd_i) out_q <= data_q;
    end

    assign powered = (ctrl_q.rng != RNG_OFF);
    assign ctrl_o  = ctrl_bits;
    assign data_o  = data_q;
    assign code_o  = powered ? out_q : '0;
    assign oe_o    = powered;
    assign range_o = ctrl_q.rng;

    // R3: reserved control bits never hold a 1
    assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_bits & ~CTRL_MASK) == '0);

    // R5: run bit low empties the data register on the next edge
    assert_clear_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_q.run |=> (data_q == '0));

    // R6: immediate mode output tracks the data register one edge later
    assert_imm_follow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_q.upd_tmr |=> (out_q == $past(data_q)));

    // R7: timer mode output is frozen between strobes
    assert_tmr_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_q.upd_tmr && !tmr_upd_i) |=> $stable(out_q));

endmodule

// File: rtl/dacc_rdmux.sv
module dacc_rdmux
    import dacc_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          rd_i,
    input  regsel_e                       sel_i,
    input  logic [NUM_CH-1:0]             ch_oh_i,
    input  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_i,
    input  logic [NUM_CH-1:0][CODE_W-1:0] data_i,
    output logic [BUS_W-1:0]              rdata_o
);
    logic [BUS_W-1:0] rd_val;
    logic [BUS_W-1:0] rdata_q;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_oh_i[i]) begin
                if (sel_i == SEL_CTRL)      rd_val = {{(BUS_W-CTRL_W){1'b0}}, ctrl_i[i]};
                else if (sel_i == SEL_DATA) rd_val = pack_code(data_i[i]);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)     rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_val;
    end

    assign rdata_o = rdata_q;

    // R9: a read that hits no register returns zero
    assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && (ch_oh_i == '0)) |=> (rdata_o == '0));

endmodule

// File: rtl/dacc_regbank.sv
module dacc_regbank
    import dacc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     bus_wr_i,
    input  logic                     bus_rd_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [BUS_W-1:0]         bus_wdata_i,
    output logic [BUS_W-1:0]         bus_rdata_o,
    input  logic                     tmr_upd_i,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        dac_oe_o,
    output logic [NUM_CH*2-1:0]      dac_range_o
);
    regsel_e                       sel;
    logic [NUM_CH-1:0]             ch_oh;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all;
    logic [NUM_CH-1:0][CODE_W-1:0] data_all;

    dacc_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr_i  (bus_addr_i),
        .sel_o   (sel),
        .ch_oh_o (ch_oh)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_c;
        logic wr_d;
        assign wr_c = bus_wr_i && ch_oh[i] && (sel == SEL_CTRL);
        assign wr_d = bus_wr_i && ch_oh[i] && (sel == SEL_DATA);

        dacc_chan u_chan (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_ctrl_i (wr_c),
            .wr_data_i (wr_d),
            .wdata_i   (bus_wdata_i),
            .tmr_upd_i (tmr_upd_i),
            .ctrl_o    (ctrl_all[i]),
            .data_o    (data_all[i]),
            .code_o    (dac_code_o[i*CODE_W +: CODE_W]),
            .oe_o      (dac_oe_o[i]),
            .range_o   (dac_range_o[i*2 +: 2])
        );
    end

    dacc_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rd_i    (bus_rd_i),
        .sel_i   (sel),
        .ch_oh_i (ch_oh),
        .ctrl_i  (ctrl_all),
        .data_i  (data_all),
        .rdata_o (bus_rdata_o)
    );

endmodule

// File: tb/dacc_regbank_tb.sv
module dacc_regbank_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            tmr = 1'b0;
    logic [NCH*12-1:0] codes;
    logic [NCH-1:0]  oe;
    logic [NCH*2-1:0] rng;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dacc_regbank #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tmr_upd_i   (tmr),
        .dac_code_o  (codes),
        .dac_oe_o    (oe),
        .dac_range_o (rng)
    );

    function automatic logic [11:0] code_of(input int ch);
        return codes[ch*12 +: 12];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        tmr = 1'b1;
        @(negedge clk);
        tmr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < NCH; i++) begin
            bus_read(AW'(8*i), v);     chk("R1 ctrl reset", v, 32'h0);
            bus_read(AW'(8*i + 4), v); chk("R1 data reset", v, 32'h0);
        end
        chk("R1 codes reset", 32'(codes), 32'h0);
        chk("R1 oe reset", 32'(oe), 32'h0);
        chk("R1 range reset", 32'(rng), 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        for (int i = 0; i < NCH; i++) bus_write(AW'(8*i), 32'h11);
        for (int i = 0; i < NCH; i++) bus_write(AW'(8*i + 4), {4'hF, 12'h3A0 + 12'(i), 16'hFFFF});
        for (int i = 0; i < NCH; i++) begin
            bus_read(AW'(8*i + 4), v);
            chk("R2 R4 data map", v, {4'h0, 12'h3A0 + 12'(i), 16'h0});
            bus_read(AW'(8*i), v);
            chk("R2 ctrl map", v, 32'h11);
            chk("R6 code follows", 32'(code_of(i)), 32'(12'h3A0 + 12'(i)));
        end
    endtask

    task automatic t_ctrl_rsvd();
        logic [31:0] v;
        bus_write(AW'(8), 32'hFFFF_FFFF);
        bus_read(AW'(8), v);
        chk("R3 reserved ctrl bits", v, 32'h33);
        bus_write(AW'(8), 32'h11);
    endtask

    task automatic t_imm();
        bus_write(AW'(4), 32'h0ABC_0000);
        chk("R6 code not yet", 32'(code_of(0)), 32'h3A0);
        @(negedge clk);
        chk("R6 code updated", 32'(code_of(0)), 32'hABC);
        chk("R8 range ext", 32'(rng[1:0]), 32'h1);
        chk("R8 oe on", 32'(oe[0]), 32'h1);
    endtask

    task automatic t_timer();
        logic [31:0] v;
        bus_write(AW'(16), 32'h31);
        bus_write(AW'(20), 32'h0123_0000);
        repeat (3) @(negedge clk);
        chk("R7 held without strobe", 32'(code_of(2)), 32'h3A2);
        strobe();
        chk("R7 loaded on strobe", 32'(code_of(2)), 32'h123);
        bus_write(AW'(20), 32'h0456_0000);
        @(negedge clk);
        chk("R7 held after write", 32'(code_of(2)), 32'h123);
        // strobe and data write on the same edge
        @(negedge clk);
        tmr = 1'b1; wr = 1'b1; addr = AW'(20); wdata = 32'h0789_0000;
        @(negedge clk);
        tmr = 1'b0; wr = 1'b0;
        chk("R7 same-edge loads old", 32'(code_of(2)), 32'h456);
        bus_read(AW'(20), v);
        chk("R7 same-edge data stored", v, 32'h0789_0000);
        chk("R7 still old", 32'(code_of(2)), 32'h456);
        strobe();
        chk("R7 next strobe", 32'(code_of(2)), 32'h789);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        bus_write(AW'(24), 32'h02);
        @(negedge clk);
        bus_read(AW'(28), v);
        chk("R5 cleared data", v, 32'h0);
        chk("R5 code follows clear", 32'(code_of(3)), 32'h0);
        chk("R8 range int", 32'(rng[7:6]), 32'h2);
        bus_write(AW'(28), 32'h0555_0000);
        bus_read(AW'(28), v);
        chk("R5 write ignored", v, 32'h0);
        bus_write(AW'(24), 32'h12);
        bus_read(AW'(28), v);
        chk("R5 no restore", v, 32'h0);
    endtask

    task automatic t_pd();
        bus_write(AW'(0), 32'h10);
        chk("R8 pd code", 32'(code_of(0)), 32'h0);
        chk("R8 pd oe", 32'(oe[0]), 32'h0);
        chk("R8 pd range", 32'(rng[1:0]), 32'h0);
        bus_write(AW'(0), 32'h13);
        chk("R8 code restored", 32'(code_of(0)), 32'hABC);
        chk("R8 range supply", 32'(rng[1:0]), 32'h3);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(AW'(2), 32'hFFFF_FFFF);
        bus_write(AW'(36), 32'h0FFF_0000);
        bus_write(AW'(32), 32'h0000_0000);
        bus_read(AW'(2), v);  chk("R9 unmapped read 02", v, 32'h0);
        bus_read(AW'(36), v); chk("R9 unmapped read 24", v, 32'h0);
        bus_read(AW'(60), v); chk("R9 unmapped read 3C", v, 32'h0);
        bus_read(AW'(0), v);  chk("R9 ctrl0 untouched", v, 32'h13);
        bus_read(AW'(4), v);  chk("R9 data0 untouched", v, 32'h0ABC_0000);
        chk("R9 code0 untouched", 32'(code_of(0)), 32'hABC);
        chk("R9 code1 untouched", 32'(code_of(1)), 32'h3A1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_ctrl_rsvd();
        t_imm();
        t_timer();
        t_clear();
        t_pd();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule